// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one transfer request into the pin-level waveform of a four-clock bus cycle. The cycle runs on a bus where the low eight lines carry the address first and data afterwards. A requester presents a 20-bit address, a write flag, a memory/IO flag and a write byte. The block accepts the request only while it is idle. It then steps through the states T1, T2, T3 and T4. On the way it drives the address-latch pulse, the read and write strobes, the transfer direction, the active-low data enable and the memory/IO select.

The upper four address lines also carry status. In T1 they show address bits 19 to 16, and after T1 they show a status nibble. The middle byte of the address stays on its own lines for the whole cycle. A low `ready` at the end of T3 inserts wait states. A read byte is captured on the edge that leaves T3 or the last wait state, and it is presented together with a one-cycle `done` in T4. The pad driver is modelled as an output value, an output enable and a separate input, so that the tristate buffer stays outside the block.

Top module: `bus_cycle_seq`

## Requirements
- R1: When `req_valid` is high while `req_ready` is high, the block accepts the request on that clock edge. `ale` is high in the next cycle (T1) and `req_ready` is low from T1 to T4. With `ready` high, `done` is high exactly three cycles after T1.
- R2: In T1, `ale` is 1, `ad_oe` is 1, `ad_o` equals address bits 7:0, `a_hi` equals address bits 19:16, `a_mid` equals address bits 15:8, and `den_n` is 1.
- R3: From T2 through T4, `a_hi` carries the status nibble {0, 0, io flag, write flag}, with bit 3 first. `a_mid` holds address bits 15:8 from T1 through T4.
- R4: In a read, `rd_n` is 0 in T2, in T3 and in every wait state. `ad_oe` is 0 from T2 through T4. `dt_r` is 0 from T1 through T4.
- R5: In a write, `wr_n` is 0 in T2, in T3 and in every wait state. `rd_n` stays 1. `dt_r` is 1 from T1 through T4. `ad_oe` is 1 and `ad_o` equals the write byte from T2 through T4.
- R6: `den_n` is 0 in T2, in T3 and in wait states. It is 1 in T1, in T4 and while idle.
- R7: With parameter `MEM_LOW`=1, `mio` equals the io flag from T1 through T4, so memory is selected by 0. With `MEM_LOW`=0, `mio` is the inverse of the io flag.
- R8: While `ready` is low at the edge ending T3 or a wait state, the block stays in a wait state. In a wait state the strobes and `den_n` keep their T3 levels and `done` stays 0. A read captures `ad_i` on the edge that enters T4, and `rdata` shows it while `done` is high.
- R9: In T4, `done` is 1 and `rd_n`, `wr_n` and `den_n` are all 1. The next cycle is idle, with `req_ready` at 1.
- R10: After reset the block is idle. `req_ready` is 1, `ale` and `ad_oe` are 0, and `rd_n`, `wr_n`, `den_n` and `dt_r` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | High while idle; a request is accepted then |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory |
| req_wdata | input | 8 | Byte to write |
| ready | input | 1 | Low at the end of T3 inserts wait states |
| ad_i | input | 8 | Value seen on the shared lines |
| ad_o | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable of the shared lines |
| a_mid | output | 8 | Address bits 15:8 |
| a_hi | output | 4 | Address bits 19:16 in T1, status afterwards |
| ale | output | 1 | Address latch pulse, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| den_n | output | 1 | Data enable, active low |
| mio | output | 1 | Memory/IO select, polarity set by `MEM_LOW` |
| done | output | 1 | High in T4 |
| rdata | output | 8 | Byte captured by a read |

## Verification
The assertions assume that `ready` is a clean level at each rising edge. They also assume that a request held high while the block is busy is simply not taken, so the checker only relates `req_valid` to `ale` when `req_ready` is high. The stimulus changes every input at the falling edge. It raises `req_valid` only while the block is idle, and it presents the read byte in T3 or the wait states, so that a capture at the wrong edge shows up as a mismatch. The sweep covers both directions, both spaces and zero to two wait states, and it runs a second instance with the select polarity inverted.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter bit MEM_LOW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [19:0] req_addr,
  input  logic        req_write,
  input  logic        req_io,
  input  logic [7:0]  req_wdata,
  input  logic        ready,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  output logic [7:0]  a_mid,
  output logic [3:0]  a_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic        dt_r,
  output logic        den_n,
  output logic        mio,
  output logic        done,
  output logic [7:0]  rdata
);
  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;
  st_t st;

  logic [19:0] addr_q;
  logic [7:0]  wdata_q, rdata_q;
  logic        wr_q, io_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          io_q    <= req_io;
          st      <= S_T1;
        end
        S_T1: st <= S_T2;
        S_T2: st <= S_T3;
        S_T3, S_TW: if (ready) begin
          if (!wr_q) rdata_q <= ad_i;
          st <= S_T4;
        end else begin
          st <= S_TW;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_cyc, in_t1, in_mid, in_t4, drv_wr;
  assign in_cyc = (st != S_IDLE);
  assign in_t1  = (st == S_T1);
  assign in_mid = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign in_t4  = (st == S_T4);
  assign drv_wr = wr_q && (in_mid || in_t4);

  assign req_ready = !in_cyc;
  assign ale       = in_t1;
  assign a_hi      = in_t1 ? addr_q[19:16] : (in_cyc ? {2'b00, io_q, wr_q} : 4'h0);
  assign a_mid     = in_cyc ? addr_q[15:8] : 8'h00;
  assign ad_oe     = in_t1 || drv_wr;
  assign ad_o      = in_t1 ? addr_q[7:0] : (drv_wr ? wdata_q : 8'h00);
  assign rd_n      = !(in_mid && !wr_q);
  assign wr_n      = !(in_mid && wr_q);
  assign den_n     = !in_mid;
  assign dt_r      = in_cyc ? wr_q : 1'b1;
  assign mio       = MEM_LOW ? io_q : !io_q;
  assign done      = in_t4;
  assign rdata     = rdata_q;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       ready,
  input logic       ad_oe,
  input logic [7:0] a_mid,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       dt_r,
  input logic       den_n,
  input logic       done
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);
  assert_t1_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (den_n && ad_oe && rd_n && wr_n && !req_ready));
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_mid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(a_mid));
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !dt_r) |=> (!ad_oe && !rd_n && !dt_r));
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && dt_r) |=> (ad_oe && !wr_n && dt_r));
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready) |=> !done);
  assert_t4_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n && !ale));
  assert_t4_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ready(ready), .ad_oe(ad_oe), .a_mid(a_mid), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n), .done(done)
);

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_i = '0;
  logic req_ready, ale, ad_oe, rd_n, wr_n, dt_r, den_n, mio, done;
  logic [7:0] ad_o, a_mid, rdata;
  logic [3:0] a_hi;
  logic x_req_ready, x_ale, x_ad_oe, x_rd_n, x_wr_n, x_dt_r, x_den_n, x_mio, x_done;
  logic [7:0] x_ad_o, x_a_mid, x_rdata;
  logic [3:0] x_a_hi;
  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  bus_cycle_seq #(.MEM_LOW(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
    .ready(ready), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .a_mid(a_mid), .a_hi(a_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n), .mio(mio),
    .done(done), .rdata(rdata));

  bus_cycle_seq #(.MEM_LOW(1'b0)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(x_req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
    .ready(ready), .ad_i(ad_i), .ad_o(x_ad_o), .ad_oe(x_ad_oe), .a_mid(x_a_mid), .a_hi(x_a_hi),
    .ale(x_ale), .rd_n(x_rd_n), .wr_n(x_wr_n), .dt_r(x_dt_r), .den_n(x_den_n), .mio(x_mio),
    .done(x_done), .rdata(x_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(input logic [19:0] a, input logic w, input logic io,
                     input logic [7:0] wd, input logic [7:0] rb, input int nw);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_io = io; req_wdata = wd;
    ready = 1'b0; ad_i = ~rb;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R1 ale in T1", ale, 1'b1);
    chk("R1 busy in T1", req_ready, 1'b0);
    chk("R2 T1 pins", {ad_oe, ad_o, a_hi, a_mid, den_n}, {1'b1, a[7:0], a[19:16], a[15:8], 1'b1});
    chk("R4/R5 dir T1", dt_r, w);
    chk("R7 select", {mio, x_mio}, {io, !io});
    @(negedge clk); #1;
    chk("R3 status T2", {a_hi, a_mid}, {2'b00, io, w, a[15:8]});
    chk("R4/R5 strobes T2", {rd_n, wr_n, ale}, {w, !w, 1'b0});
    chk("R6 den T2", den_n, 1'b0);
    chk("R4/R5 lines T2", {ad_oe, ad_o}, w ? {1'b1, wd} : 9'h000);
    ad_i = rb;
    @(negedge clk); #1;
    chk("R4/R5 strobes T3", {rd_n, wr_n, den_n, dt_r}, {w, !w, 1'b0, w});
    chk("R1 no done T3", done, 1'b0);
    ready = (nw == 0);
    for (int k = 0; k < nw; k++) begin
      @(negedge clk); #1;
      chk("R8 wait state", {done, rd_n, wr_n, den_n, a_hi}, {1'b0, w, !w, 1'b0, 2'b00, io, w});
      ready = (k == nw - 1);
    end
    @(negedge clk); #1;
    ad_i = rb ^ 8'hFF;
    chk("R9 T4", {done, rd_n, wr_n, den_n}, 4'b1111);
    chk("R4/R5 lines T4", {ad_oe, ad_o, dt_r}, w ? {1'b1, wd, 1'b1} : 10'h000);
    chk("R3 status T4", {a_hi, a_mid}, {2'b00, io, w, a[15:8]});
    chk("R7 select T4", {mio, x_mio}, {io, !io});
    if (!w) chk("R8 read capture", rdata, rb);
    @(negedge clk); #1;
    chk("R9 idle after T4", {req_ready, done, ale, den_n, ad_oe}, 5'b10010);
    ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset", {req_ready, ale, ad_oe, rd_n, wr_n, den_n, dt_r}, 7'b1001111);
    for (int i = 0; i < 4; i++)
      for (int w = 0; w < 2; w++)
        for (int io = 0; io < 2; io++)
          for (int nw = 0; nw < 3; nw++) begin
            logic [19:0] a;
            logic [7:0] wd, rb;
            a  = 20'h3B5C7 * (i + 1) ^ {i[3:0], 16'h0F0F};
            wd = 8'h3C + 8'(i * 37 + nw);
            rb = 8'hA1 ^ 8'(i * 29 + w * 5 + io * 3 + nw);
            run(a, w[0], io[0], wd, rb, nw);
          end
    run(20'hFFFFF, 1'b0, 1'b1, 8'h00, 8'hFF, 3);
    run(20'h00000, 1'b1, 1'b0, 8'hFF, 8'h00, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule